// File: doc/BRIEF.md
# Ethernet DMA Control and Status Registers

This block is the software-visible register file of a descriptor-driven Ethernet DMA. A 32-bit bus reaches it with byte addresses. The register index is the byte address shifted right by two. The block holds the following registers:

- bus mode
- operation control
- interrupt enable
- interrupt status
- the two descriptor list base pointers and the two current-descriptor pointers
- a bank of plain filter-table words

It drives the control bits and pointers to the transmit and receive engines. It emits a one-cycle start strobe when software demands a transmit poll. It raises one level-sensitive interrupt.

The engines report events by pulsing bits on a 32-bit set vector. Those bits collect in the status register until software clears them by writing ones. Writing a list base pointer rewinds the matching current pointer to that base. A bus-mode software-reset bit can be written but never reads back as one. A fixed version word identifies the block.

Top module: `eth_dma_csr`

## Requirements
- R1: After reset every register reads zero and all outputs are low. The version word at index 0x008 always reads 0x1012, and writes to it have no effect.
- R2: A write is taken on the clock edge where `bus_wr` is high. Reads are combinational from `bus_addr`. The index is `bus_addr[11:2]`. The register indices are: bus mode 0x3C0, transmit poll 0x3C1, receive poll 0x3C2, receive base 0x3C3, transmit base 0x3C4, status 0x3C5, control 0x3C6, interrupt enable 0x3C7, current transmit pointer 0x3D2, and current receive pointer 0x3D3.
- R3: A write to status clears each status bit whose written data bit is one and keeps every other bit.
- R4: Each bit of `sts_set` that is high at a clock edge sets the same status bit, including bits a simultaneous write clears. The set wins over the clear.
- R5: `irq` is high exactly when status AND interrupt enable is nonzero. It reflects the registers as updated at the most recent edge.
- R6: A write to a list base stores the value and loads the same value into the matching current pointer. The current pointers can also be written directly. They appear on `cur_tx_ptr` and `cur_rx_ptr`.
- R7: The bus mode register stores the written value with bit 0 forced to zero.
- R8: A write to index 0x3C1 makes `tx_poll` high for exactly the one cycle after that edge. Index 0x3C1 stores nothing and reads zero.
- R9: `rx_enable` follows control bit 1 and `tx_run` follows control bit 13.
- R10: The 16 filter words at indices 0x0C0 to 0x0CF, and the receive poll word, read back what was last written. Any other index reads zero and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 12 | Byte address |
| bus_wr | input | 1 | Write enable |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| sts_set | input | 32 | Status set pulses from the engines |
| tx_poll | output | 1 | One-cycle transmit start strobe |
| irq | output | 1 | Interrupt level |
| rx_enable | output | 1 | Receive enable |
| tx_run | output | 1 | Transmit start |
| cur_tx_ptr | output | 32 | Current transmit descriptor pointer |
| cur_rx_ptr | output | 32 | Current receive descriptor pointer |

## Verification
The hardest case to reach is an engine set pulse landing in the same cycle as a software clear of the very same status bit. Random traffic seldom lines the two up. Directed steps therefore write all-ones to status while driving chosen set bits. The random phase then mixes nonzero set vectors into status writes about a quarter of the time. Interrupt enable is rewritten between events, so `irq` is seen both rising from an enable change and falling from a clear.

// File: rtl/eth_dma_csr.sv
module eth_dma_csr #(
  parameter int ADDR_W    = 12,
  parameter int DATA_W    = 32,
  parameter int NUM_FILT  = 16,
  parameter int FILT_BASE = 'h0C0,
  parameter logic [31:0] VERSION = 32'h0000_1012
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [DATA_W-1:0] sts_set,
  output logic              tx_poll,
  output logic              irq,
  output logic              rx_enable,
  output logic              tx_run,
  output logic [DATA_W-1:0] cur_tx_ptr,
  output logic [DATA_W-1:0] cur_rx_ptr
);
  localparam int IDX_W = ADDR_W - 2;
  localparam logic [IDX_W-1:0] I_VER  = IDX_W'('h008);
  localparam logic [IDX_W-1:0] I_BUS  = IDX_W'('h3C0);
  localparam logic [IDX_W-1:0] I_TXP  = IDX_W'('h3C1);
  localparam logic [IDX_W-1:0] I_RXP  = IDX_W'('h3C2);
  localparam logic [IDX_W-1:0] I_RXB  = IDX_W'('h3C3);
  localparam logic [IDX_W-1:0] I_TXB  = IDX_W'('h3C4);
  localparam logic [IDX_W-1:0] I_STS  = IDX_W'('h3C5);
  localparam logic [IDX_W-1:0] I_CTL  = IDX_W'('h3C6);
  localparam logic [IDX_W-1:0] I_IEN  = IDX_W'('h3C7);
  localparam logic [IDX_W-1:0] I_CTX  = IDX_W'('h3D2);
  localparam logic [IDX_W-1:0] I_CRX  = IDX_W'('h3D3);
  localparam int CTL_RXEN = 1;
  localparam int CTL_TXGO = 13;

  logic [IDX_W-1:0]  idx;
  logic              unused_lo;
  logic [DATA_W-1:0] bus_mode, rx_poll_w, rx_base, tx_base, status, control, int_en;
  logic [DATA_W-1:0] filt [NUM_FILT];
  logic [DATA_W-1:0] filt_rd;

  assign idx       = bus_addr[ADDR_W-1:2];
  assign unused_lo = ^bus_addr[1:0];

  function automatic logic hit(input logic [IDX_W-1:0] r);
    return bus_wr && (idx == r);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_mode   <= '0;
      rx_poll_w  <= '0;
      rx_base    <= '0;
      tx_base    <= '0;
      cur_rx_ptr <= '0;
      cur_tx_ptr <= '0;
      status     <= '0;
      control    <= '0;
      int_en     <= '0;
      tx_poll    <= 1'b0;
    end else begin
      tx_poll <= hit(I_TXP);
      status  <= (status & ~(hit(I_STS) ? bus_wdata : '0)) | sts_set;
      if (hit(I_BUS)) bus_mode  <= {bus_wdata[DATA_W-1:1], 1'b0};
      if (hit(I_RXP)) rx_poll_w <= bus_wdata;
      if (hit(I_CTL)) control   <= bus_wdata;
      if (hit(I_IEN)) int_en    <= bus_wdata;
      if (hit(I_RXB)) begin
        rx_base    <= bus_wdata;
        cur_rx_ptr <= bus_wdata;
      end else if (hit(I_CRX)) begin
        cur_rx_ptr <= bus_wdata;
      end
      if (hit(I_TXB)) begin
        tx_base    <= bus_wdata;
        cur_tx_ptr <= bus_wdata;
      end else if (hit(I_CTX)) begin
        cur_tx_ptr <= bus_wdata;
      end
    end
  end

  for (genvar g = 0; g < NUM_FILT; g++) begin : g_filt
    always_ff @(posedge clk) begin
      if (!rst_n)                           filt[g] <= '0;
      else if (hit(IDX_W'(FILT_BASE + g)))  filt[g] <= bus_wdata;
    end
  end

  always_comb begin
    filt_rd = '0;
    for (int k = 0; k < NUM_FILT; k++)
      if (idx == IDX_W'(FILT_BASE + k)) filt_rd = filt[k];
  end

  always_comb begin
    case (idx)
      I_VER:   bus_rdata = VERSION;
      I_BUS:   bus_rdata = bus_mode;
      I_RXP:   bus_rdata = rx_poll_w;
      I_RXB:   bus_rdata = rx_base;
      I_TXB:   bus_rdata = tx_base;
      I_STS:   bus_rdata = status;
      I_CTL:   bus_rdata = control;
      I_IEN:   bus_rdata = int_en;
      I_CTX:   bus_rdata = cur_tx_ptr;
      I_CRX:   bus_rdata = cur_rx_ptr;
      default: bus_rdata = filt_rd;
    endcase
  end

  assign irq       = |(status & int_en);
  assign rx_enable = control[CTL_RXEN];
  assign tx_run    = control[CTL_TXGO];
endmodule

// File: rtl/eth_dma_csr_chk.sv
module eth_dma_csr_chk #(
  parameter int IDX_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic [IDX_W-1:0] idx,
  input logic             wr,
  input logic [31:0]      wdata,
  input logic [31:0]      rdata,
  input logic [31:0]      sts_set,
  input logic [31:0]      status,
  input logic             tx_poll,
  input logic             irq,
  input logic [31:0]      cur_rx
);
  assert_version_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (idx == IDX_W'('h008)) |-> (rdata == 32'h1012));
  assert_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && idx == IDX_W'('h3C5) && sts_set == '0) |=> ((status & $past(wdata)) == '0));
  assert_set_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_set != '0) |=> ((status & $past(sts_set)) == $past(sts_set)));
  assert_irq_src_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (status != '0));
  assert_reload_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && idx == IDX_W'('h3C3)) |=> (cur_rx == $past(wdata)));
  assert_swrst_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (idx == IDX_W'('h3C0)) |-> !rdata[0]);
  assert_poll_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_poll |-> $past(wr && idx == IDX_W'('h3C1)));
endmodule

bind eth_dma_csr eth_dma_csr_chk #(.IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .idx(idx), .wr(bus_wr), .wdata(bus_wdata),
  .rdata(bus_rdata), .sts_set(sts_set), .status(status), .tx_poll(tx_poll),
  .irq(irq), .cur_rx(cur_rx_ptr)
);

// File: tb/test_eth_dma_csr.sv
module test_eth_dma_csr;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst_n = 1'b0, bus_wr = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, sts_set = '0;
  logic [31:0] bus_rdata, cur_tx_ptr, cur_rx_ptr;
  logic        tx_poll, irq, rx_enable, tx_run;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  eth_dma_csr i_eth_dma_csr (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sts_set(sts_set),
    .tx_poll(tx_poll), .irq(irq), .rx_enable(rx_enable), .tx_run(tx_run),
    .cur_tx_ptr(cur_tx_ptr), .cur_rx_ptr(cur_rx_ptr));

  logic [31:0] m_bus, m_rxp, m_rxb, m_txb, m_sts, m_ctl, m_ien, m_ctx, m_crx;
  logic [31:0] m_filt [16];
  logic        m_poll;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] model_rd(logic [9:0] i);
    if (i >= 10'h0C0 && i <= 10'h0CF) return m_filt[i - 10'h0C0];
    case (i)
      10'h008: return 32'h1012;
      10'h3C0: return m_bus;
      10'h3C2: return m_rxp;
      10'h3C3: return m_rxb;
      10'h3C4: return m_txb;
      10'h3C5: return m_sts;
      10'h3C6: return m_ctl;
      10'h3C7: return m_ien;
      10'h3D2: return m_ctx;
      10'h3D3: return m_crx;
      default: return 32'h0;
    endcase
  endfunction

  task automatic model_reset();
    m_bus = 0; m_rxp = 0; m_rxb = 0; m_txb = 0; m_sts = 0; m_ctl = 0;
    m_ien = 0; m_ctx = 0; m_crx = 0; m_poll = 0;
    for (int k = 0; k < 16; k++) m_filt[k] = 0;
  endtask

  task automatic cyc(logic wr, logic [9:0] i, logic [31:0] d, logic [31:0] s);
    bus_wr = wr; bus_addr = {i, 2'b00}; bus_wdata = d; sts_set = s;
    @(posedge clk);
    m_poll = wr && i == 10'h3C1;
    m_sts = (m_sts & ~((wr && i == 10'h3C5) ? d : 32'h0)) | s;
    if (wr) begin
      if (i >= 10'h0C0 && i <= 10'h0CF) m_filt[i - 10'h0C0] = d;
      case (i)
        10'h3C0: m_bus = d & ~32'h1;
        10'h3C2: m_rxp = d;
        10'h3C3: begin m_rxb = d; m_crx = d; end
        10'h3C4: begin m_txb = d; m_ctx = d; end
        10'h3C6: m_ctl = d;
        10'h3C7: m_ien = d;
        10'h3D2: m_ctx = d;
        10'h3D3: m_crx = d;
        default: ;
      endcase
    end
    @(negedge clk);
    bus_wr = 0; sts_set = 0;
    check("R8 tx_poll", {31'b0, tx_poll}, {31'b0, m_poll});
    check("R5 irq", {31'b0, irq}, {31'b0, |(m_sts & m_ien)});
    check("R9 ctl outs", {30'b0, tx_run, rx_enable}, {30'b0, m_ctl[13], m_ctl[1]});
    check("R6 cur ptrs", cur_tx_ptr ^ {cur_rx_ptr[15:0], cur_rx_ptr[31:16]},
          m_ctx ^ {m_crx[15:0], m_crx[31:16]});
  endtask

  task automatic rd(string req, logic [9:0] i);
    bus_addr = {i, 2'b00};
    #1;
    check(req, bus_rdata, model_rd(i));
  endtask

  localparam logic [9:0] MAP [14] = '{10'h008, 10'h3C0, 10'h3C1, 10'h3C2, 10'h3C3,
    10'h3C4, 10'h3C5, 10'h3C6, 10'h3C7, 10'h3D2, 10'h3D3, 10'h0C0, 10'h0CF, 10'h123};

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog actual hang expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] seed;
    seed = 32'd1234;
    void'($urandom(seed));
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    for (int k = 0; k < 14; k++) rd("R1 reset", MAP[k]);
    check("R1 outs", {28'b0, tx_poll, irq, rx_enable, tx_run}, 32'h0);
    // directed
    cyc(1, 10'h008, 32'hFFFF_FFFF, 0); rd("R1 version", 10'h008);
    cyc(1, 10'h3C0, 32'hFFFF_FFFF, 0); rd("R7 swrst bit", 10'h3C0);
    cyc(1, 10'h3C3, 32'h1000_0040, 0); rd("R6 rx base", 10'h3C3); rd("R6 rx cur", 10'h3D3);
    cyc(1, 10'h3D3, 32'h1000_0080, 0); rd("R6 rx cur wr", 10'h3D3);
    cyc(1, 10'h3C4, 32'h2000_0000, 0); rd("R6 tx cur", 10'h3D2);
    cyc(1, 10'h3C1, 32'hDEAD_BEEF, 0); rd("R8 poll reads 0", 10'h3C1);
    cyc(0, 10'h3C1, 0, 0);
    cyc(1, 10'h3C7, 32'h0001_0001, 0);
    cyc(0, 10'h000, 0, 32'h0001_0041); rd("R4 set", 10'h3C5);
    cyc(1, 10'h3C5, 32'hFFFF_FFFF, 32'h0000_0080); rd("R4 set beats clear", 10'h3C5);
    cyc(1, 10'h3C5, 32'h0000_0080, 32'h0000_0080); rd("R4 same bit", 10'h3C5);
    cyc(1, 10'h3C5, 32'h0000_0080, 0); rd("R3 clear", 10'h3C5);
    cyc(1, 10'h3C6, 32'h0000_2002, 0);
    cyc(1, 10'h123, 32'h5555_AAAA, 0); rd("R10 unmapped", 10'h123);
    cyc(1, 10'h0CF, 32'h0BAD_CAFE, 0); rd("R10 filt", 10'h0CF);
    cyc(1, 10'h3C2, 32'h0000_0003, 0); rd("R10 rx poll", 10'h3C2);
    // random
    for (int n = 0; n < 3000; n++) begin
      logic [9:0]  i;
      logic [31:0] s;
      i = MAP[$urandom_range(0, 13)];
      if ($urandom_range(0, 7) == 0) i = 10'h0C0 + 10'($urandom_range(0, 15));
      s = ($urandom_range(0, 3) == 0) ? ($urandom & $urandom) : 32'h0;
      cyc($urandom_range(0, 1) == 1, i, $urandom, s);
      rd("R2 random read", MAP[$urandom_range(0, 13)]);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule